// File: doc/BRIEF.md
# Backlight PWM Generator with Shadowed Timing

The block drives one pulse-width-modulated pin for a display backlight. A prescaler divides the input clock. A period counter then runs through one PWM cycle of programmable length. The pin is high for a programmable number of counts at the start of every cycle and low for the rest of it. Software reaches the block through a small single-cycle write port. Reads are combinational: an address selects a word on the read-data output.

The prescaler, period and high-time settings are written into a shadow bank. They reach the live counters only when software releases a commit bit, that is, writes it to 1 and then back to 0. While the output is running, the live bank is swapped only at the end of a PWM cycle, so no cycle is ever cut short. While the output is stopped, the swap happens at once. A direct-update mode makes the live bank track the shadow bank on every clock with no commit. The live bank can be read back at its own addresses.

Top module: `bl_pwm`

## Requirements
- R1: After reset, `pwm_out` is low, the output is disabled, and every register address reads zero.
- R2: The period counter advances once every (P+1) clocks while enabled, where P is the live prescaler value.
- R3: A PWM cycle lasts (N+1) counts and `pwm_out` is high for the first H counts of it, where N is the live period value and H is the live high time. The first count of a cycle is visible at the clock edge that registers the enable write.
- R4: Writes to the prescaler, period or high-time fields change only the shadow bank. The live bank and the waveform are unchanged until a commit, unless direct mode is on.
- R5: A commit happens when bit 0 of the commit word (address 0x04) is written 0 while it holds 1. Writing 1 alone does nothing.
  - While running, the shadow bank is loaded at the next period wrap. This includes a wrap in the very cycle of the commit.
  - While disabled, the shadow bank is loaded at the commit edge.
- R6: If H is greater than or equal to N+1, `pwm_out` stays high for the whole cycle. If H is 0, it stays low.
- R7: Writing 0 to enable bit 0 (address 0x00) drives `pwm_out` low from that edge and holds both counters at zero. Enabling again starts a fresh cycle at count 0.
- R8: While bit 1 of the configuration word (address 0x08) is set, the live bank takes the shadow values one clock after any shadow write, with no commit.
- R9: The register layout is as follows. Unused bits read zero, and a write to one word leaves the other words unchanged.
  - Configuration word: prescaler in bits 25:16 and direct-mode bit 1.
  - Timing word (address 0x0C): period in bits 11:0 and high time in bits 28:16.
  - Live copies: the live prescaler reads back at address 0x10 in bits 25:16, and the live period and high time read back at address 0x14 in the timing-word layout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per asserted clock |
| addr | input | 8 | Word address for writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwm_out | output | 1 | Backlight PWM pin |

## Verification
The commit handshake and the period wrap can land on the same clock edge. That is the case where a one-cycle-late pending flag would push the new settings out by a whole period. With the prescaler at zero, the bench times the commit-release write so that it is registered at the last count of a cycle. It expects the new waveform to begin on the very next count. A second run releases the commit early in a long cycle and expects the old waveform to finish in full before the switch.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 8;

   // word addresses
   localparam logic [ADDR_W-1:0] OFF_ENABLE      = 8'h00;
   localparam logic [ADDR_W-1:0] OFF_COMMIT      = 8'h04;
   localparam logic [ADDR_W-1:0] OFF_CFG         = 8'h08;
   localparam logic [ADDR_W-1:0] OFF_TIMING      = 8'h0C;
   localparam logic [ADDR_W-1:0] OFF_LIVE_CFG    = 8'h10;
   localparam logic [ADDR_W-1:0] OFF_LIVE_TIMING = 8'h14;

   // field positions
   localparam int ENABLE_BIT = 0;
   localparam int COMMIT_BIT = 0;
   localparam int DIRECT_BIT = 1;
   localparam int PRESC_LSB  = 16;
   localparam int PERIOD_LSB = 0;
   localparam int HIGH_LSB   = 16;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
   import bl_pwm_pkg::*;
#(
   parameter int PRESC_W   = 10,
   parameter int PERIOD_W  = 12,
   parameter int HIGH_W    = 13,
   parameter bit DIRECT_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [PRESC_W-1:0]  act_presc,
   input  logic [PERIOD_W-1:0] act_period,
   input  logic [HIGH_W-1:0]   act_high,
   output logic [DATA_W-1:0]   rdata,
   output logic                en,
   output logic                direct,
   output logic                commit_pulse,
   output logic [PRESC_W-1:0]  sh_presc,
   output logic [PERIOD_W-1:0] sh_period,
   output logic [HIGH_W-1:0]   sh_high
);
   logic wr_enable, wr_commit, wr_cfg, wr_timing;
   logic commit_q;
   logic unused_wdata_bits;

   assign wr_enable = wr_en && (addr == OFF_ENABLE);
   assign wr_commit = wr_en && (addr == OFF_COMMIT);
   assign wr_cfg    = wr_en && (addr == OFF_CFG);
   assign wr_timing = wr_en && (addr == OFF_TIMING);
   assign unused_wdata_bits = ^wdata;

   // R5: release of a held commit bit is the load request
   assign commit_pulse = wr_commit && commit_q && !wdata[COMMIT_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en        <= 1'b0;
         commit_q  <= 1'b0;
         sh_presc  <= '0;
         sh_period <= '0;
         sh_high   <= '0;
      end else begin
         if (wr_enable) en       <= wdata[ENABLE_BIT];
         if (wr_commit) commit_q <= wdata[COMMIT_BIT];
         if (wr_cfg)    sh_presc <= wdata[PRESC_LSB +: PRESC_W];
         if (wr_timing) begin
            sh_period <= wdata[PERIOD_LSB +: PERIOD_W];
            sh_high   <= wdata[HIGH_LSB +: HIGH_W];
         end
      end
   end

   generate
      if (DIRECT_EN) begin : g_direct
         logic direct_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      direct_q <= 1'b0;
            else if (wr_cfg) direct_q <= wdata[DIRECT_BIT];
         end
         assign direct = direct_q;
      end else begin : g_no_direct
         assign direct = 1'b0;
      end
   endgenerate

   // R9: readback, unused bits zero
   always_comb begin
      rdata = '0;
      case (addr)
         OFF_ENABLE: rdata[ENABLE_BIT] = en;
         OFF_COMMIT: rdata[COMMIT_BIT] = commit_q;
         OFF_CFG: begin
            rdata[PRESC_LSB +: PRESC_W] = sh_presc;
            rdata[DIRECT_BIT]           = direct;
         end
         OFF_TIMING: begin
            rdata[PERIOD_LSB +: PERIOD_W] = sh_period;
            rdata[HIGH_LSB +: HIGH_W]     = sh_high;
         end
         OFF_LIVE_CFG: rdata[PRESC_LSB +: PRESC_W] = act_presc;
         OFF_LIVE_TIMING: begin
            rdata[PERIOD_LSB +: PERIOD_W] = act_period;
            rdata[HIGH_LSB +: HIGH_W]     = act_high;
         end
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/bl_pwm_bank.sv
module bl_pwm_bank #(
   parameter int PRESC_W  = 10,
   parameter int PERIOD_W = 12,
   parameter int HIGH_W   = 13
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                direct,
   input  logic                commit_pulse,
   input  logic                boundary,
   input  logic [PRESC_W-1:0]  sh_presc,
   input  logic [PERIOD_W-1:0] sh_period,
   input  logic [HIGH_W-1:0]   sh_high,
   output logic [PRESC_W-1:0]  act_presc,
   output logic [PERIOD_W-1:0] act_period,
   output logic [HIGH_W-1:0]   act_high,
   output logic                pending
);
   logic request;
   logic load;

   // R5: a request raised in the wrap cycle lands in that same wrap
   assign request = pending || commit_pulse;
   // R8: direct mode copies every clock
   assign load    = direct || (request && (!en || boundary));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_presc  <= '0;
         act_period <= '0;
         act_high   <= '0;
         pending    <= 1'b0;
      end else begin
         if (load) begin
            act_presc  <= sh_presc;
            act_period <= sh_period;
            act_high   <= sh_high;
         end
         pending <= load ? 1'b0 : request;
      end
   end
endmodule

// File: rtl/bl_pwm_timebase.sv
module bl_pwm_timebase #(
   parameter int PRESC_W  = 10,
   parameter int PERIOD_W = 12,
   parameter int HIGH_W   = 13
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic [PRESC_W-1:0]  act_presc,
   input  logic [PERIOD_W-1:0] act_period,
   input  logic [HIGH_W-1:0]   act_high,
   output logic                tick,
   output logic                boundary,
   output logic [PRESC_W-1:0]  presc_cnt,
   output logic [PERIOD_W-1:0] cnt,
   output logic                pwm_out
);
   // compare with >= so a live value shrunk in direct mode still wraps
   assign tick     = en && (presc_cnt >= act_presc);
   assign boundary = tick && (cnt >= act_period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         presc_cnt <= '0;
         cnt       <= '0;
      end else if (!en) begin
         presc_cnt <= '0;
         cnt       <= '0;
      end else begin
         presc_cnt <= tick ? '0 : presc_cnt + 1'b1;
         if (tick) cnt <= boundary ? '0 : cnt + 1'b1;
      end
   end

   // R3, R6: high for counts below H; H above N holds the pin high
   assign pwm_out = en && (HIGH_W'(cnt) < act_high);
endmodule

// File: rtl/bl_pwm.sv
module bl_pwm
   import bl_pwm_pkg::*;
#(
   parameter int PRESC_W   = 10,
   parameter int PERIOD_W  = 12,
   parameter int HIGH_W    = PERIOD_W + 1,
   parameter bit DIRECT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              pwm_out
);
   generate
      if (PRESC_LSB + PRESC_W > DATA_W) begin : g_bad_presc
         $error("prescaler field exceeds word");
      end
      if (HIGH_LSB + HIGH_W > DATA_W) begin : g_bad_high
         $error("high-time field exceeds word");
      end
      if (PERIOD_LSB + PERIOD_W > HIGH_LSB) begin : g_bad_period
         $error("period field overlaps high-time field");
      end
      if (HIGH_W <= PERIOD_W) begin : g_bad_ratio
         $error("high-time must be wider than period");
      end
   endgenerate

   logic                en_w, direct_w, commit_pulse_w;
   logic                tick_w, boundary_w, pending_w;
   logic [PRESC_W-1:0]  sh_presc_w, act_presc_w, presc_cnt_w;
   logic [PERIOD_W-1:0] sh_period_w, act_period_w, cnt_w;
   logic [HIGH_W-1:0]   sh_high_w, act_high_w;

   bl_pwm_regs #(
      .PRESC_W(PRESC_W), .PERIOD_W(PERIOD_W), .HIGH_W(HIGH_W), .DIRECT_EN(DIRECT_EN)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .act_presc(act_presc_w), .act_period(act_period_w), .act_high(act_high_w),
      .rdata(rdata), .en(en_w), .direct(direct_w), .commit_pulse(commit_pulse_w),
      .sh_presc(sh_presc_w), .sh_period(sh_period_w), .sh_high(sh_high_w)
   );

   bl_pwm_bank #(
      .PRESC_W(PRESC_W), .PERIOD_W(PERIOD_W), .HIGH_W(HIGH_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .en(en_w), .direct(direct_w),
      .commit_pulse(commit_pulse_w), .boundary(boundary_w),
      .sh_presc(sh_presc_w), .sh_period(sh_period_w), .sh_high(sh_high_w),
      .act_presc(act_presc_w), .act_period(act_period_w), .act_high(act_high_w),
      .pending(pending_w)
   );

   bl_pwm_timebase #(
      .PRESC_W(PRESC_W), .PERIOD_W(PERIOD_W), .HIGH_W(HIGH_W)
   ) u_tb (
      .clk(clk), .rst_n(rst_n), .en(en_w),
      .act_presc(act_presc_w), .act_period(act_period_w), .act_high(act_high_w),
      .tick(tick_w), .boundary(boundary_w), .presc_cnt(presc_cnt_w), .cnt(cnt_w),
      .pwm_out(pwm_out)
   );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
   parameter int PRESC_W  = 10,
   parameter int PERIOD_W = 12,
   parameter int HIGH_W   = 13
) (
   input logic                clk,
   input logic                rst_n,
   input logic                en,
   input logic                direct,
   input logic                commit_pulse,
   input logic                pending,
   input logic                tick,
   input logic                boundary,
   input logic [PRESC_W-1:0]  presc_cnt,
   input logic [PERIOD_W-1:0] cnt,
   input logic [PERIOD_W-1:0] sh_period,
   input logic [PERIOD_W-1:0] act_period,
   input logic [HIGH_W-1:0]   act_high,
   input logic                pwm_out
);
   // R2
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !tick) |=> (!en || $stable(cnt)));

   // R7
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0 && presc_cnt == '0));

   // R5
   commit_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && boundary) |=> !pending);

   // R4
   shadow_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!direct && !pending && !commit_pulse) |=> ($stable(act_period) && $stable(act_high)));

   // R6
   full_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && act_high > HIGH_W'(act_period)) |-> pwm_out);

   // R6
   full_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_high == '0) |-> !pwm_out);

   // R8
   direct_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      direct |=> (act_period == $past(sh_period)));
endmodule

bind bl_pwm bl_pwm_chk #(
   .PRESC_W(PRESC_W), .PERIOD_W(PERIOD_W), .HIGH_W(HIGH_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en_w), .direct(direct_w),
   .commit_pulse(commit_pulse_w), .pending(pending_w), .tick(tick_w),
   .boundary(boundary_w), .presc_cnt(presc_cnt_w), .cnt(cnt_w),
   .sh_period(sh_period_w), .act_period(act_period_w), .act_high(act_high_w),
   .pwm_out(pwm_out)
);

// File: tb/bl_pwm_tb.sv
`timescale 1ns/1ps
module bl_pwm_tb;
   localparam logic [7:0] A_EN = 8'h00, A_COMMIT = 8'h04, A_CFG = 8'h08,
                          A_TIM = 8'h0C, A_LCFG = 8'h10, A_LTIM = 8'h14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        pwm_out;

   int vectors = 0;
   int miscompares = 0;
   logic  exp_q[$];
   string tag_q[$];

   always #10 clk = ~clk;

   bl_pwm u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
   );

   function automatic logic [31:0] tim(input int n, input int h);
      return (32'(h) << 16) | 32'(n);
   endfunction

   function automatic logic [31:0] cfg(input int p, input bit dir);
      return (32'(p) << 16) | (32'(dir) << 1);
   endfunction

   task automatic check32(input logic [31:0] act, input logic [31:0] exp, input string tag);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // called at a negedge; returns at the next negedge
   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      addr = a;
      #1;
      check32(rdata, exp, tag);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load_idle(input int p, input int n, input int h);
      bus_wr(A_CFG, cfg(p, 1'b0));
      bus_wr(A_TIM, tim(n, h));
      bus_wr(A_COMMIT, 32'd1);
      bus_wr(A_COMMIT, 32'd0);
   endtask

   // expected pin per clock from the start of a fresh cycle
   task automatic push_wave(input int p, input int n, input int h, input int count, input string tag);
      for (int k = 0; k < count; k++) begin
         int c;
         c = (k / (p + 1)) % (n + 1);
         exp_q.push_back(c < h);
         tag_q.push_back(tag);
      end
   endtask

   task automatic push_const(input logic v, input int count, input string tag);
      for (int k = 0; k < count; k++) begin
         exp_q.push_back(v);
         tag_q.push_back(tag);
      end
   endtask

   task automatic drain;
      wait (exp_q.size() == 0);
      @(negedge clk);
   endtask

   // monitor: pops one expected pin value per clock
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (exp_q.size() > 0) begin
            logic  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            vectors++;
            if (pwm_out !== e) begin
               miscompares++;
               $display("FAIL %s: pwm_out got %b expected %b at %0t", t, pwm_out, e, $time);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      check32({31'd0, pwm_out}, 32'd0, "R1 pwm");
      bus_rd(A_EN, 0, "R1 enable");
      bus_rd(A_COMMIT, 0, "R1 commit");
      bus_rd(A_CFG, 0, "R1 cfg");
      bus_rd(A_TIM, 0, "R1 timing");
      bus_rd(A_LCFG, 0, "R1 live cfg");
      bus_rd(A_LTIM, 0, "R1 live timing");

      // R2 R3 prescaled waveform, R5 immediate load while idle
      load_idle(2, 3, 2);
      bus_rd(A_LTIM, tim(3, 2), "R5 idle load");
      bus_rd(A_LCFG, cfg(2, 1'b0), "R5 idle load prescaler");
      bus_wr(A_EN, 32'd1);
      push_wave(2, 3, 2, 24, "R2 R3 waveform");
      drain();

      // R6 full on, equal, full off
      bus_wr(A_EN, 32'd0);
      load_idle(1, 3, 6);
      bus_wr(A_EN, 32'd1);
      push_const(1'b1, 16, "R6 high above period");
      drain();
      bus_wr(A_EN, 32'd0);
      load_idle(1, 3, 4);
      bus_wr(A_EN, 32'd1);
      push_const(1'b1, 16, "R6 high equals period plus one");
      drain();
      bus_wr(A_EN, 32'd0);
      load_idle(0, 3, 0);
      bus_wr(A_EN, 32'd1);
      push_const(1'b0, 8, "R6 high zero");
      drain();

      // R7 stop mid-cycle, fresh restart
      bus_wr(A_EN, 32'd0);
      load_idle(0, 4, 3);
      bus_wr(A_EN, 32'd1);
      idle(7);
      bus_wr(A_EN, 32'd0);
      push_const(1'b0, 6, "R7 stopped low");
      idle(6);
      bus_wr(A_EN, 32'd1);
      push_wave(0, 4, 3, 10, "R7 fresh restart");
      drain();

      // R4 shadow only, R5 commit released in the wrap cycle
      bus_wr(A_EN, 32'd0);
      load_idle(0, 3, 1);
      bus_wr(A_TIM, tim(5, 4));
      bus_rd(A_LTIM, tim(3, 1), "R4 live unchanged");
      bus_rd(A_TIM, tim(5, 4), "R9 shadow readback");
      bus_wr(A_EN, 32'd1);
      push_wave(0, 3, 1, 4, "R4 old settings");
      push_wave(0, 5, 4, 12, "R5 coincident commit");
      bus_wr(A_COMMIT, 32'd1);
      idle(2);
      bus_wr(A_COMMIT, 32'd0);
      drain();

      // R5 early release waits for the wrap
      bus_wr(A_EN, 32'd0);
      load_idle(0, 9, 3);
      bus_wr(A_TIM, tim(2, 1));
      bus_wr(A_EN, 32'd1);
      push_wave(0, 9, 3, 10, "R5 old cycle completes");
      push_wave(0, 2, 1, 9, "R5 new after wrap");
      bus_wr(A_COMMIT, 32'd1);
      bus_rd(A_COMMIT, 32'd1, "R9 commit bit readback");
      bus_wr(A_COMMIT, 32'd0);
      drain();
      bus_rd(A_LTIM, tim(2, 1), "R5 live after wrap");

      // R8 direct mode
      bus_wr(A_EN, 32'd0);
      load_idle(0, 4, 0);
      bus_wr(A_CFG, cfg(0, 1'b1));
      bus_wr(A_EN, 32'd1);
      bus_wr(A_TIM, tim(4, 13'h1FFF));
      idle(1);
      bus_rd(A_LTIM, tim(4, 13'h1FFF), "R8 live follows shadow");
      push_const(1'b1, 4, "R8 direct waveform");
      drain();
      bus_wr(A_CFG, cfg(0, 1'b0));
      bus_wr(A_TIM, tim(4, 0));
      idle(1);
      bus_rd(A_LTIM, tim(4, 13'h1FFF), "R4 direct off holds live");
      push_const(1'b1, 4, "R4 direct off waveform");
      drain();

      // R9 field layout
      bus_wr(A_EN, 32'd0);
      bus_wr(A_TIM, 32'hFFFF_FFFF);
      bus_rd(A_TIM, 32'h1FFF_0FFF, "R9 timing fields");
      bus_wr(A_CFG, 32'hFFFF_FFFF);
      bus_rd(A_CFG, 32'h03FF_0002, "R9 cfg fields");
      bus_wr(A_TIM, 32'd0);
      bus_rd(A_CFG, 32'h03FF_0002, "R9 cfg untouched by timing write");
      bus_wr(A_EN, 32'hFFFF_FFFF);
      bus_rd(A_EN, 32'd1, "R9 enable field");
      bus_wr(A_EN, 32'd0);
      idle(1);
      check32({31'd0, pwm_out}, 32'd0, "R7 low after stop");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule